// File: doc/BRIEF.md
# Dual-Channel Burst Serial Port

This block is a synchronous serial port. Its shift engine moves a burst of one to eight bytes with no host action between bytes. The bytes sit in an eight-slot byte store. The host fills the slots while the port is idle and reads them back at any time. Each byte that arrives on the data input is written over the slot that supplied the outgoing byte. After a burst, the store therefore holds the replies.

Two pin channels share the single shifter. Each channel has a select input, a clock pin, a data input and a data output. A configuration input chooses the channel that takes part. The other channel keeps its drivers off.

The serial clock has two sources:
- **Internal:** a programmable prescaler generates it, and the clock pin is driven.
- **External:** the clock pin is an input and the shifter follows its edges.

An optional select-qualified mode gates the transfer by the channel's active-low select line. Lowering that line in the middle of a byte aborts the burst and raises an error flag.

Top module: `dual_sio_fifo`

## Requirements
- R1: After reset, busy, done_irq and err are low and sck_o is high on both channels. With all configuration inputs at zero, only channel 0 has its data output enabled.
- R2: The store has 8 slots of 8 bits, addressed 0 to 7. A write through wr_en/wr_addr/wr_data takes effect while the port is idle. rd_data shows the slot at rd_addr combinationally.
- R3: Byte k of a burst is sent from slot k, most significant bit first. so_o changes only on falling clock edges and is stable at each rising edge.
- R4: The data input is sampled on rising clock edges, most significant bit first. Each received byte replaces slot k. Slots beyond the last byte of the burst keep their contents.
- R5: A start pulse while idle transfers cfg_last+1 bytes, where cfg_last is the byte count minus one (0 to 7). At the end, busy falls and done_irq is high for exactly one cycle, in the same cycle.
- R6: With the internal clock (cfg_ext_clk = 0), SCK idles high and has a period of 8*(cfg_div+1) clock cycles. sck_oe is high for the chosen channel.
- R7: With the external clock (cfg_ext_clk = 1), sck_oe is low on both channels. Shifting follows the edges of the chosen sck_i after a two-flop synchroniser.
- R8: Only the channel named by cfg_chan (0 or 1) has sck_oe or so_oe high. The data input of the other channel has no effect on the received bytes.
- R9: In select mode (cfg_cs_mode = 1, cs_n_i active low), while the chosen cs_n_i is high, sck_oe and so_oe are low and a started burst waits with no clock edges. The burst proceeds once cs_n_i goes low.
- R10: In select mode, cs_n_i rising after a byte's first falling edge and before its eighth rising edge aborts the burst:
  - busy falls, err rises, and done_irq stays low.
  - The slot of the partial byte is unchanged; bytes completed earlier have been replaced.
  - err clears at the next start.
- R11: While busy, host writes, start pulses and changes to the configuration inputs have no effect. The configuration is captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host slot write strobe |
| wr_addr | input | 3 | Host write slot index |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 3 | Host read slot index |
| rd_data | output | 8 | Contents of slot rd_addr |
| cfg_chan | input | 1 | Chosen channel |
| cfg_ext_clk | input | 1 | 1 = clock from pin, 0 = internal prescaler |
| cfg_cs_mode | input | 1 | 1 = select-qualified transfer |
| cfg_div | input | 4 | Prescale; SCK period 8*(cfg_div+1) cycles |
| cfg_last | input | 3 | Burst length minus one |
| start | input | 1 | Begin a burst (idle only) |
| busy | output | 1 | Burst in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Burst aborted by select release |
| cs_n_i | input | 2 | Per-channel active-low select |
| sck_i | input | 2 | Per-channel clock pin input |
| si_i | input | 2 | Per-channel serial data input |
| sck_o | output | 2 | Per-channel clock pin output value |
| sck_oe | output | 2 | Per-channel clock driver enable |
| so_o | output | 2 | Per-channel serial data output value |
| so_oe | output | 2 | Per-channel data driver enable |

## Verification
The hardest state to reach is the mid-byte abort. The select line has to rise after some bits of a byte have moved but before the byte completes, and the outcome must be distinguished from a pause between bytes. The bench counts clock edges on the chosen channel's pins and releases the select right after a chosen rising edge inside the second byte. It then checks that the first slot was replaced and the second was not.

The window in which pokes must be ignored is reached in a similar way. At a counted falling edge, the bench writes a slot, pulses start and changes the channel and length. It then confirms that the burst, the drivers and the store show no trace of these changes.

// File: rtl/sif_pkg.sv
package sif_pkg;
  // width of one serial data unit
  localparam int SIF_BYTE_W   = 8;
  // log2 of the half-period unit in system clocks (min period = 2 * 2**UNIT_LOG)
  localparam int SIF_UNIT_LOG = 2;
endpackage

// File: rtl/sif_slot_ram.sv
module sif_slot_ram #(
  parameter  int DEPTH = 8,
  parameter  int W     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= '0;
      else if (we && (waddr == AW'(i)))     q <= wdata;
    end
    assign slot[i] = q;
  end

  assign rdata_a = slot[raddr_a];
  assign rdata_b = slot[raddr_b];
endmodule

// File: rtl/sif_pin_bank.sv
module sif_pin_bank #(
  parameter  int NCH = 2,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  sel,
  input  logic           drive_sck,
  input  logic           drive_so,
  input  logic           sck_q,
  input  logic           so_q,
  input  logic [NCH-1:0] cs_n_i,
  input  logic [NCH-1:0] sck_i,
  input  logic [NCH-1:0] si_i,
  output logic [NCH-1:0] sck_o,
  output logic [NCH-1:0] sck_oe,
  output logic [NCH-1:0] so_o,
  output logic [NCH-1:0] so_oe,
  output logic           cs_act,
  output logic           sck_s,
  output logic           si_s
);
  // synchronised {cs_n, sck, si} per channel
  logic [2:0] syn [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [2:0] s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 3'b110;
        s2_q <= 3'b110;
      end else begin
        s1_q <= {cs_n_i[c], sck_i[c], si_i[c]};
        s2_q <= s1_q;
      end
    end
    assign syn[c]    = s2_q;
    assign sck_o[c]  = sck_q;
    assign so_o[c]   = so_q;
    assign sck_oe[c] = (sel == CW'(c)) && drive_sck;
    assign so_oe[c]  = (sel == CW'(c)) && drive_so;
  end

  logic [2:0] cur;
  assign cur    = syn[sel];
  assign cs_act = ~cur[2];
  assign sck_s  = cur[1];
  assign si_s   = cur[0];
endmodule

// File: rtl/sif_edge_gen.sv
module sif_edge_gen #(
  parameter  int DIV_W    = 4,
  parameter  int UNIT_LOG = sif_pkg::SIF_UNIT_LOG,
  localparam int CW       = DIV_W + UNIT_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_sck_s,
  output logic             sck_q,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [CW-1:0] cnt_q, cnt_d, half_m1;
  logic          sck_d, prev_q, int_tick, int_run;

  // half period = (div+1) * 2**UNIT_LOG cycles
  assign half_m1  = {div, {UNIT_LOG{1'b1}}};
  assign int_run  = run && !ext;
  assign int_tick = int_run && (cnt_q == half_m1);

  always_comb begin
    cnt_d = '0;
    if (int_run) cnt_d = int_tick ? '0 : cnt_q + 1'b1;
    sck_d = 1'b1;
    if (run) sck_d = int_tick ? ~sck_q : sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      prev_q <= ext_sck_s;
    end
  end

  assign fall_ev = run && (ext ? (prev_q && !ext_sck_s) : (int_tick &&  sck_q));
  assign rise_ev = run && (ext ? (!prev_q && ext_sck_s) : (int_tick && !sck_q));
endmodule

// File: rtl/dual_sio_fifo.sv
module dual_sio_fifo #(
  parameter  int DEPTH    = 8,
  parameter  int NCH      = 2,
  parameter  int DIV_W    = 4,
  localparam int W        = sif_pkg::SIF_BYTE_W,
  localparam int AW       = $clog2(DEPTH),
  localparam int BW       = $clog2(W),
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data,
  input  logic [CHW-1:0]   cfg_chan,
  input  logic             cfg_ext_clk,
  input  logic             cfg_cs_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [AW-1:0]    cfg_last,
  input  logic             start,
  output logic             busy,
  output logic             done_irq,
  output logic             err,
  input  logic [NCH-1:0]   cs_n_i,
  input  logic [NCH-1:0]   sck_i,
  input  logic [NCH-1:0]   si_i,
  output logic [NCH-1:0]   sck_o,
  output logic [NCH-1:0]   sck_oe,
  output logic [NCH-1:0]   so_o,
  output logic [NCH-1:0]   so_oe
);
  // state
  logic             busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic             mid_q, mid_d, so_q, so_d;
  logic [AW-1:0]    byte_q, byte_d, last_q, last_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [CHW-1:0]   ch_q, ch_d;
  logic             ext_q, ext_d, csm_q, csm_d;
  logic [DIV_W-1:0] div_q, div_d;

  // interconnect
  logic          cs_act, sck_s, si_s, sck_q, fall_ev, rise_ev, run, abort;
  logic          byte_end, eng_we, mem_we;
  logic [W-1:0]  tx_byte, rx_full, mem_wdata;
  logic [AW-1:0] mem_waddr;

  assign run      = busy_q && (!csm_q || cs_act);
  assign abort    = busy_q && csm_q && !cs_act && mid_q;
  assign rx_full  = {rx_q[W-2:0], si_s};
  assign byte_end = rise_ev && (bit_q == BW'(W-1));
  assign eng_we   = busy_q && !abort && byte_end;
  assign mem_we   = eng_we || (!busy_q && wr_en);
  assign mem_waddr = busy_q ? byte_q  : wr_addr;
  assign mem_wdata = busy_q ? rx_full : wr_data;

  sif_slot_ram #(.DEPTH(DEPTH), .W(W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(rd_addr), .rdata_a(rd_data), .raddr_b(byte_q), .rdata_b(tx_byte)
  );

  sif_edge_gen #(.DIV_W(DIV_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .ext(ext_q), .div(div_q),
    .ext_sck_s(sck_s), .sck_q(sck_q), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sif_pin_bank #(.NCH(NCH)) u_pins (
    .clk(clk), .rst_n(rst_n), .sel(ch_q),
    .drive_sck(!ext_q && (!csm_q || cs_act)), .drive_so(!csm_q || cs_act),
    .sck_q(sck_q), .so_q(so_q), .cs_n_i(cs_n_i), .sck_i(sck_i), .si_i(si_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe),
    .cs_act(cs_act), .sck_s(sck_s), .si_s(si_s)
  );

  // next state
  always_comb begin
    busy_d = busy_q; done_d = 1'b0;  err_d = err_q;
    mid_d  = mid_q;  so_d   = so_q;  byte_d = byte_q;
    bit_d  = bit_q;  rx_d   = rx_q;
    ch_d   = ch_q;   ext_d  = ext_q; csm_d = csm_q;
    div_d  = div_q;  last_d = last_q;
    if (!busy_q) begin
      ch_d  = cfg_chan;    ext_d  = cfg_ext_clk; csm_d = cfg_cs_mode;
      div_d = cfg_div;     last_d = cfg_last;
      if (start) begin
        busy_d = 1'b1; byte_d = '0; bit_d = '0; mid_d = 1'b0; err_d = 1'b0;
      end
    end else if (abort) begin
      busy_d = 1'b0; err_d = 1'b1; mid_d = 1'b0; bit_d = '0;
    end else begin
      if (fall_ev) begin
        so_d  = tx_byte[BW'(W-1) - bit_q];
        mid_d = 1'b1;
      end
      if (rise_ev) begin
        rx_d  = rx_full;
        bit_d = bit_q + 1'b1;
        if (byte_end) begin
          mid_d = 1'b0;
          bit_d = '0;
          if (byte_q == last_q) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            byte_d = byte_q + 1'b1;
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; err_q  <= 1'b0;
      mid_q  <= 1'b0; so_q   <= 1'b1; byte_q <= '0;
      bit_q  <= '0;   rx_q   <= '0;   ch_q   <= '0;
      ext_q  <= 1'b0; csm_q  <= 1'b0; div_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d; done_q <= done_d; err_q  <= err_d;
      mid_q  <= mid_d;  so_q   <= so_d;   byte_q <= byte_d;
      bit_q  <= bit_d;  rx_q   <= rx_d;   ch_q   <= ch_d;
      ext_q  <= ext_d;  csm_q  <= csm_d;  div_q  <= div_d;
      last_q <= last_d;
    end
  end

  assign busy     = busy_q;
  assign done_irq = done_q;
  assign err      = err_q;
endmodule

// File: rtl/sif_chk.sv
module sif_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done_irq,
  input logic           err,
  input logic           cfg_ext_clk,
  input logic [NCH-1:0] sck_oe,
  input logic [NCH-1:0] so_oe
);
  // R5
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($past(busy) && !busy));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R8
  so_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(so_oe));

  // R8
  sck_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sck_oe));

  // R7
  ext_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_ext_clk) |=> (sck_oe == '0));

  // R6
  sck_with_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sck_oe & ~so_oe) == '0));

  // R10
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !done_irq));
endmodule

bind dual_sio_fifo sif_chk #(.NCH(NCH)) u_sif_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_irq(done_irq), .err(err),
  .cfg_ext_clk(cfg_ext_clk), .sck_oe(sck_oe), .so_oe(so_oe)
);

// File: tb/dual_sio_fifo_bench.sv
module dual_sio_fifo_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, start, busy, done_irq, err;
  logic [2:0] wr_addr, rd_addr, cfg_last;
  logic [7:0] wr_data, rd_data;
  logic       cfg_chan, cfg_ext_clk, cfg_cs_mode;
  logic [3:0] cfg_div;
  logic [1:0] cs_n_i, sck_i, si_i, sck_o, sck_oe, so_o, so_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] txd [8];
  logic [7:0] rxd [8];

  always #(CLK_P/2) clk = ~clk;

  dual_sio_fifo u_dual_sio_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_chan(cfg_chan), .cfg_ext_clk(cfg_ext_clk),
    .cfg_cs_mode(cfg_cs_mode), .cfg_div(cfg_div), .cfg_last(cfg_last), .start(start),
    .busy(busy), .done_irq(done_irq), .err(err), .cs_n_i(cs_n_i), .sck_i(sck_i),
    .si_i(si_i), .sck_o(sck_o), .sck_oe(sck_oe), .so_o(so_o), .so_oe(so_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_slot(input int k, input int nrep);
    return (k < nrep) ? rxd[k] : txd[k];
  endfunction

  task automatic write_slot(input int k, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(k); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill();
    for (int k = 0; k < 8; k++) begin
      txd[k] = 8'($urandom);
      rxd[k] = 8'($urandom);
      write_slot(k, txd[k]);
    end
  endtask

  task automatic check_slots(input int nrep, input string req);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd_addr = 3'(k);
      #1;
      chk(rd_data === exp_slot(k, nrep), req, int'(rd_data), int'(exp_slot(k, nrep)));
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // internal-clock burst; abort_bits > 0 releases select after that many rising edges
  task automatic run_int(input int ch, input int dv, input int n, input bit csm,
                         input int abort_bits, input bit poke);
    int bits = 0, dn = 0, f1 = -1, f2 = -1, cyc = 0;
    bit prev = 1'b1, oe_ok = 1'b1, hold_ok = 1'b1;
    logic [7:0] acc = 8'h00;
    cfg_chan = 1'(ch); cfg_ext_clk = 1'b0; cfg_cs_mode = csm;
    cfg_div = 4'(dv); cfg_last = 3'(n - 1); cs_n_i = 2'b11;
    pulse_start();
    if (csm) begin
      repeat (20) begin
        @(negedge clk);
        if (sck_o[ch] !== 1'b1 || sck_oe !== 2'b00 || so_oe !== 2'b00 || busy !== 1'b1)
          hold_ok = 1'b0;
      end
      chk(hold_ok, "R9 hold and float while select released", int'(hold_ok), 1);
      cs_n_i[ch] = 1'b0;
    end
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      wr_en = 1'b0; start = 1'b0;
      if (!csm && busy && (sck_oe !== 2'(1 << ch) || so_oe !== 2'(1 << ch))) oe_ok = 1'b0;
      if (prev && !sck_o[ch]) begin
        if (f1 < 0) f1 = cyc; else if (f2 < 0) f2 = cyc;
        si_i[ch]     = rxd[bits / 8][7 - (bits % 8)];
        si_i[1 - ch] = ~si_i[ch];
        if (poke && bits == 2) begin
          wr_en = 1'b1; wr_addr = 3'd7; wr_data = ~txd[7]; start = 1'b1;
          cfg_last = 3'd7; cfg_chan = 1'(1 - ch);
        end
      end
      if (!prev && sck_o[ch]) begin
        acc = {acc[6:0], so_o[ch]};
        bits++;
        if (bits % 8 == 0)
          chk(acc === txd[bits / 8 - 1], "R3 transmitted byte", int'(acc), int'(txd[bits / 8 - 1]));
        if (abort_bits > 0 && bits == abort_bits) cs_n_i[ch] = 1'b1;
      end
      prev = sck_o[ch];
      if (done_irq) dn++;
      if (!busy) break;
    end
    cfg_chan = 1'(ch); cfg_last = 3'(n - 1);
    chk(f2 - f1 == 8 * (dv + 1), "R6 sck period", f2 - f1, 8 * (dv + 1));
    if (!csm) chk(oe_ok, "R8 only chosen channel driven", int'(oe_ok), 1);
    if (abort_bits > 0) begin
      chk(err === 1'b1, "R10 err raised", int'(err), 1);
      chk(dn == 0, "R10 no done pulse", dn, 0);
      @(negedge clk);
      chk(so_oe === 2'b00, "R9 outputs float after release", int'(so_oe), 0);
      check_slots(abort_bits / 8, "R10 slots after abort");
    end else begin
      chk(dn == 1, "R5 one done pulse", dn, 1);
      chk(bits == 8 * n, "R5 burst length", bits, 8 * n);
      chk(err === 1'b0, "R10 err clear after normal burst", int'(err), 0);
      check_slots(n, poke ? "R11 pokes ignored, slots" : "R4 slots replaced");
    end
    cs_n_i = 2'b11;
  endtask

  // external-clock burst, bench drives the clock pin
  task automatic run_ext(input int ch, input int n);
    int dn = 0;
    bit oe_ok = 1'b1;
    logic [7:0] acc;
    cfg_chan = 1'(ch); cfg_ext_clk = 1'b1; cfg_cs_mode = 1'b0;
    cfg_last = 3'(n - 1); sck_i = 2'b11; cs_n_i = 2'b11;
    pulse_start();
    for (int k = 0; k < n; k++) begin
      acc = 8'h00;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        sck_i[ch] = 1'b0;
        si_i[ch] = rxd[k][7 - b];
        si_i[1 - ch] = ~rxd[k][7 - b];
        repeat (6) @(negedge clk);
        if (sck_oe !== 2'b00 || so_oe !== 2'(1 << ch)) oe_ok = 1'b0;
        acc = {acc[6:0], so_o[ch]};
        sck_i[ch] = 1'b1;
        repeat (6) begin
          @(negedge clk);
          if (done_irq) dn++;
        end
      end
      chk(acc === txd[k], "R7 byte sent on pin clock", int'(acc), int'(txd[k]));
    end
    chk(oe_ok, "R7 clock pin not driven", int'(oe_ok), 1);
    chk(busy === 1'b0, "R5 idle after burst", int'(busy), 0);
    chk(dn == 1, "R5 one done pulse", dn, 1);
    check_slots(n, "R4 slots replaced");
    cfg_ext_clk = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cfg_chan = 1'b0; cfg_ext_clk = 1'b0; cfg_cs_mode = 1'b0; cfg_div = '0; cfg_last = '0;
    cs_n_i = 2'b11; sck_i = 2'b11; si_i = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done_irq === 1'b0 && err === 1'b0, "R1 status low",
        int'({busy, done_irq, err}), 0);
    chk(sck_o === 2'b11, "R1 sck idle high", int'(sck_o), 3);
    chk(so_oe === 2'b01, "R1 channel 0 driven", int'(so_oe), 1);

    fill();
    check_slots(0, "R2 host write and read");
    cfg_chan = 1'b1;
    repeat (2) @(negedge clk);
    chk(so_oe === 2'b10 && sck_oe === 2'b10, "R8 idle channel switch",
        int'({sck_oe, so_oe}), 10);

    fill(); run_int(0, 0, 1, 1'b0, 0, 1'b0);
    fill(); run_int(1, 1, 3, 1'b0, 0, 1'b1);
    fill(); run_int(0, 0, 8, 1'b0, 0, 1'b0);
    fill(); run_ext(1, 2);
    fill(); run_ext(0, 8);
    fill(); run_int(1, 0, 2, 1'b1, 0, 1'b0);
    fill(); run_int(0, 1, 3, 1'b1, 11, 1'b0);
    fill(); run_int(0, 0, 2, 1'b0, 0, 1'b0);

    for (int i = 0; i < 8; i++) begin
      int ch, dv, n;
      ch = int'($urandom % 2);
      dv = int'($urandom % 3);
      n  = 1 + int'($urandom % 8);
      fill();
      if ($urandom % 2 == 0) run_int(ch, dv, n, 1'b0, 0, 1'b0);
      else                   run_ext(ch, n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule